// File: doc/BRIEF.md
# Data Access Fault Classifier

This block sits beside the data-side translation buffer of a processor core. For each load or store it takes the virtual address, the access size, the privilege state and the result of the buffer lookup, and returns one verdict. The verdict is either a physical address with a flag that marks it uncacheable, or one fault code. Fault conditions are resolved in a fixed order, so exactly one code comes out even when several conditions hold at once. On a translation miss or a permission fault, the faulting virtual page and context are latched into a tag register, which the miss handler reads.

A small recent-translation memory sits in front of the lookup result. It holds the last two successful translations, each tagged with its page, address-space identifier, physical page, write permission and side-effect bit. These slots are valid only while the control state word presented with each request does not change. When a request hits a slot, the slot supplies the translation and the lookup input is not used.

Requests enter on a valid/ready channel and verdicts leave on a second valid/ready channel, one cycle after acceptance. The block takes a new request when its output register is empty, or when that register is being drained in the same cycle. While a verdict waits with ready low, it stays unchanged and no request is taken. The tag register is a plain status output.

Top module: `dacl_unit`

## Requirements
- R1: An access is misaligned when any of the low address bits covered by its size is set. Size codes 0, 1, 2 and 3 stand for 1, 2, 4 and 8 bytes. A misaligned access gets code 1 (alignment), which takes priority over every other outcome. The tag register does not change.
- R2: An aligned access that is both hypervisor and implicit bypasses translation. It gets code 0, its physical address is the low 40 bits of the virtual address, it is marked cacheable, and the tag register does not change.
- R3: With address masking on, the virtual address is cut to its low 32 bits before the lookup. With masking off, an address in the range 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF (bounds included) gets code 2 (out of range) and the tag register does not change.
- R4: A lookup miss gets code 3 (real-translation miss) when the access is real, and code 4 (translation miss) otherwise.
- R5: After a lookup hit, the permission checks apply in this order, and the first one that holds sets the code:
  - code 5: a non-privileged access to a privileged page;
  - code 6: a write to a page that is not writable;
  - code 7: a normal access to a no-fault-only page;
  - code 8: a no-fault access to a side-effect page.
- R6: A successful translation gets code 0. Its physical address is the physical page from the lookup, concatenated with virtual address bits 12:0. It is marked uncacheable when the page has the side-effect bit set or when physical address bit 39 is set.
- R7: Every code from 3 through 8 loads the tag register with the effective virtual address bits 63:13 in bits 63:13 and the 13-bit context in bits 12:0. No other outcome changes the tag register. Reset clears it to zero.
- R8: A recent-translation slot hits when all of the following hold: it is valid, the control state is the same as on the previous accepted request, the page matches, the address-space identifier matches, and the access is either a read or a write to a slot marked writable. A hit returns the slot's translation with code 0 and ignores the lookup input.
- R9: A successful translation from the lookup input enters slot 0 and moves the old slot 0 into slot 1. If a valid slot already holds the same page and identifier, the translation is not inserted and the slots stay as they are. The two slots never hold the same key.
- R10: An accepted request whose control state word differs from the previous accepted request invalidates both slots before that request's lookup.
- R11: A nonzero code always comes with a physical address of zero and the uncacheable flag clear.
- R12: The request-ready output is high when no verdict is pending or the pending verdict is being taken. A verdict held with response-ready low keeps every response field stable. Reset leaves no verdict pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of the access size in bytes |
| req_write | input | 1 | Store access |
| req_priv | input | 1 | Privileged mode |
| req_hpriv | input | 1 | Hypervisor mode |
| req_implicit | input | 1 | Implicit address space |
| req_amask | input | 1 | 32-bit address masking on |
| req_nofault | input | 1 | No-fault address space |
| req_real | input | 1 | Real (untranslated-context) access |
| req_asi | input | 8 | Address-space identifier |
| req_ctx | input | 13 | Context number |
| req_state | input | 64 | Control state word |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_ppn | input | 27 | Physical page number of the entry |
| tlb_priv | input | 1 | Entry is privileged-only |
| tlb_wr | input | 1 | Entry is writable |
| tlb_nfo | input | 1 | Entry allows no-fault accesses only |
| tlb_se | input | 1 | Entry has side effects |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict taken on this edge when valid |
| rsp_code | output | 4 | Fault code, 0 for success |
| rsp_pa | output | 40 | Physical address, zero on a fault |
| rsp_uncache | output | 1 | Uncacheable marker |
| tag_access | output | 64 | Latched faulting page and context |

## Verification
The bench covers several collisions. One case is a misaligned hypervisor access: a design that checks the bypass first would return an address instead of code 1. Another is the set of addresses on both edges of the unimplemented range, with masking on and off: an off-by-one bound would translate an address it should reject, or reject one it should translate. The bench runs every mix of the permission bits; a wrong priority would give the second fault's code. Other cases re-present a page with the lookup showing a miss. That catches a recent-translation memory that never hits, evicts the wrong slot, keeps entries after a state change, or lets a write through a read-only slot. A final case holds response-ready low and catches a design that drops or overwrites the pending verdict.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

  typedef enum logic [3:0] {
    F_NONE      = 4'd0,
    F_ALIGN     = 4'd1,
    F_RANGE     = 4'd2,
    F_REAL_MISS = 4'd3,
    F_MMU_MISS  = 4'd4,
    F_PRIV      = 4'd5,
    F_PROT      = 4'd6,
    F_NFO       = 4'd7,
    F_SIDEFX    = 4'd8
  } dacl_fault_e;

endpackage

// File: rtl/dacl_vaddr.sv
module dacl_vaddr #(
  parameter int VA_W = 64,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      size,
  input  logic            amask,
  input  logic            hpriv,
  input  logic            implicit_acc,
  output logic [VA_W-1:0] eff_va,
  output logic            mis,
  output logic            bypass,
  output logic            out_rng
);
  localparam int MASK_W = 32;

  logic [2:0] low_mask;

  always_comb begin
    case (size)
      2'd0:    low_mask = 3'b000;
      2'd1:    low_mask = 3'b001;
      2'd2:    low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
  end

  assign mis     = |(va[2:0] & low_mask);
  assign bypass  = hpriv & implicit_acc;
  assign eff_va  = amask ? {{(VA_W-MASK_W){1'b0}}, va[MASK_W-1:0]} : va;
  assign out_rng = !amask && (va >= HOLE_LO) && (va <= HOLE_HI);

endmodule

// File: rtl/dacl_recent.sv
module dacl_recent #(
  parameter int VPN_W = 51,
  parameter int PPN_W = 27,
  parameter int ASI_W = 8,
  parameter int ST_W  = 64,
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [ST_W-1:0]  st_in,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASI_W-1:0] lk_asi,
  input  logic             lk_wr,
  input  logic             fill,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr,
  input  logic             fill_se,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_se
);
  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [ASI_W-1:0] asi;
    logic [PPN_W-1:0] ppn;
    logic             wr;
    logic             se;
  } slot_t;

  slot_t             slot_q [NSLOT];
  logic [NSLOT-1:0]  v_q, v_eff, v_nxt, match, present;
  logic [ST_W-1:0]   st_q;
  logic              same_st;

  assign same_st = (st_q == st_in);
  assign v_eff   = same_st ? v_q : '0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign present[i] = v_eff[i] && (slot_q[i].vpn == lk_vpn) && (slot_q[i].asi == lk_asi);
    assign match[i]   = present[i] && (!lk_wr || slot_q[i].wr);
  end

  always_comb begin
    hit     = |match;
    hit_ppn = '0;
    hit_se  = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_ppn = slot_q[i].ppn;
        hit_se  = slot_q[i].se;
      end
    end
  end

  always_comb begin
    v_nxt = v_eff;
    if (fill && !(|present)) v_nxt = {v_eff[NSLOT-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      st_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (acc) begin
      v_q  <= v_nxt;
      st_q <= st_in;
      if (fill && !(|present)) begin
        slot_q[0] <= '{vpn: lk_vpn, asi: lk_asi, ppn: fill_ppn, wr: fill_wr, se: fill_se};
        for (int i = 1; i < NSLOT; i++) slot_q[i] <= slot_q[i-1];
      end
    end
  end

  for (genvar i = 1; i < NSLOT; i++) begin : g_uniq
    // R9
    no_dup_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[0] && v_q[i]) |-> !((slot_q[0].vpn == slot_q[i].vpn) && (slot_q[0].asi == slot_q[i].asi)));
  end

  // R10
  state_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (st_in != st_q)) |=> (v_q[NSLOT-1:1] == '0));

endmodule

// File: rtl/dacl_check.sv
module dacl_check
  import dacl_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 40,
  parameter int PG_SH = 13
) (
  input  logic                  mis,
  input  logic                  bypass,
  input  logic                  out_rng,
  input  logic [PA_W-1:0]       raw_pa,
  input  logic [VA_W-1:0]       eff_va,
  input  logic [PG_SH-1:0]      ctx,
  input  logic                  wr,
  input  logic                  pv,
  input  logic                  nofault,
  input  logic                  real_acc,
  input  logic                  c_hit,
  input  logic [PA_W-PG_SH-1:0] c_ppn,
  input  logic                  c_se,
  input  logic                  t_hit,
  input  logic [PA_W-PG_SH-1:0] t_ppn,
  input  logic                  t_priv,
  input  logic                  t_wr,
  input  logic                  t_nfo,
  input  logic                  t_se,
  output dacl_fault_e           code,
  output logic [PA_W-1:0]       pa,
  output logic                  uc,
  output logic                  tag_ld,
  output logic [VA_W-1:0]       tag_val,
  output logic                  fill
);
  localparam int PPN_W = PA_W - PG_SH;

  logic             use_page;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_se;

  assign tag_val = {eff_va[VA_W-1:PG_SH], ctx};

  always_comb begin
    code     = F_NONE;
    tag_ld   = 1'b0;
    fill     = 1'b0;
    use_page = 1'b0;
    sel_ppn  = '0;
    sel_se   = 1'b0;
    pa       = '0;
    uc       = 1'b0;
    if (mis) begin
      code = F_ALIGN;
    end else if (bypass) begin
      pa = raw_pa;
    end else if (out_rng) begin
      code = F_RANGE;
    end else if (c_hit) begin
      use_page = 1'b1;
      sel_ppn  = c_ppn;
      sel_se   = c_se;
    end else if (!t_hit) begin
      code   = real_acc ? F_REAL_MISS : F_MMU_MISS;
      tag_ld = 1'b1;
    end else if (!pv && t_priv) begin
      code   = F_PRIV;
      tag_ld = 1'b1;
    end else if (wr && !t_wr) begin
      code   = F_PROT;
      tag_ld = 1'b1;
    end else if (t_nfo && !nofault) begin
      code   = F_NFO;
      tag_ld = 1'b1;
    end else if (t_se && nofault) begin
      code   = F_SIDEFX;
      tag_ld = 1'b1;
    end else begin
      use_page = 1'b1;
      sel_ppn  = t_ppn;
      sel_se   = t_se;
      fill     = 1'b1;
    end
    if (use_page) begin
      pa = {sel_ppn, eff_va[PG_SH-1:0]};
      uc = sel_se | sel_ppn[PPN_W-1];
    end
  end

endmodule

// File: rtl/dacl_unit.sv
module dacl_unit
  import dacl_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 40,
  parameter int PG_SH = 13,
  parameter int ASI_W = 8,
  parameter int ST_W  = 64,
  parameter int NSLOT = 2,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic [1:0]            req_size,
  input  logic                  req_write,
  input  logic                  req_priv,
  input  logic                  req_hpriv,
  input  logic                  req_implicit,
  input  logic                  req_amask,
  input  logic                  req_nofault,
  input  logic                  req_real,
  input  logic [ASI_W-1:0]      req_asi,
  input  logic [PG_SH-1:0]      req_ctx,
  input  logic [ST_W-1:0]       req_state,
  input  logic                  tlb_hit,
  input  logic [PA_W-PG_SH-1:0] tlb_ppn,
  input  logic                  tlb_priv,
  input  logic                  tlb_wr,
  input  logic                  tlb_nfo,
  input  logic                  tlb_se,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [3:0]            rsp_code,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_uncache,
  output logic [VA_W-1:0]       tag_access
);
  localparam int VPN_W = VA_W - PG_SH;
  localparam int PPN_W = PA_W - PG_SH;

  logic              acc;
  logic [VA_W-1:0]   eff_va, tag_val;
  logic              mis, bypass, out_rng;
  logic              c_hit, c_se, tag_ld, fill, uc;
  logic [PPN_W-1:0]  c_ppn;
  logic [PA_W-1:0]   pa;
  dacl_fault_e       code, code_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign rsp_code  = code_q;

  dacl_vaddr #(.VA_W(VA_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_vaddr (
    .va(req_va), .size(req_size), .amask(req_amask), .hpriv(req_hpriv),
    .implicit_acc(req_implicit), .eff_va(eff_va), .mis(mis), .bypass(bypass),
    .out_rng(out_rng)
  );

  dacl_recent #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASI_W(ASI_W), .ST_W(ST_W), .NSLOT(NSLOT)) u_recent (
    .clk(clk), .rst_n(rst_n), .acc(acc), .st_in(req_state),
    .lk_vpn(eff_va[VA_W-1:PG_SH]), .lk_asi(req_asi), .lk_wr(req_write),
    .fill(fill), .fill_ppn(tlb_ppn), .fill_wr(tlb_wr), .fill_se(tlb_se),
    .hit(c_hit), .hit_ppn(c_ppn), .hit_se(c_se)
  );

  dacl_check #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH)) u_check (
    .mis(mis), .bypass(bypass), .out_rng(out_rng), .raw_pa(req_va[PA_W-1:0]),
    .eff_va(eff_va), .ctx(req_ctx), .wr(req_write), .pv(req_priv),
    .nofault(req_nofault), .real_acc(req_real), .c_hit(c_hit), .c_ppn(c_ppn),
    .c_se(c_se), .t_hit(tlb_hit), .t_ppn(tlb_ppn), .t_priv(tlb_priv),
    .t_wr(tlb_wr), .t_nfo(tlb_nfo), .t_se(tlb_se), .code(code), .pa(pa),
    .uc(uc), .tag_ld(tag_ld), .tag_val(tag_val), .fill(fill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      code_q      <= F_NONE;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      tag_access  <= '0;
    end else begin
      if (acc) begin
        rsp_valid   <= 1'b1;
        code_q      <= code;
        rsp_pa      <= pa;
        rsp_uncache <= uc;
        if (tag_ld) tag_access <= tag_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R1
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mis) |=> (rsp_code == F_ALIGN));

  // R2
  bypass_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mis && req_hpriv && req_implicit) |=>
      (rsp_code == F_NONE) && (rsp_pa == $past(req_va[PA_W-1:0])));

  // R7
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(tag_access));

  // R11
  fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != F_NONE) |-> (rsp_pa == '0) && !rsp_uncache);

  // R12
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      rsp_valid && $stable(rsp_code) && $stable(rsp_pa) && $stable(rsp_uncache));

endmodule

// File: tb/dacl_unit_bench.sv
`timescale 1ns/1ps
module dacl_unit_bench;
  localparam logic [63:0] HLO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] HHI = 64'hFFFF_7FFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_uncache;
  logic [3:0] rsp_code;
  logic [39:0] rsp_pa;
  logic [63:0] tag_access;

  logic [63:0] va = '0, st = '0;
  logic [1:0] sz = '0;
  logic wr = 0, pv = 0, hp = 0, im = 0, am = 0, nf = 0, rl = 0;
  logic [7:0] asi = '0;
  logic [12:0] ctx = '0;
  logic th = 0, tpv = 0, twr = 0, tnfo = 0, tse = 0;
  logic [26:0] tppn = '0;

  // bench model state
  logic [63:0] m_st = '0, m_tag = '0;
  logic        m_v [2];
  logic [50:0] m_vpn [2];
  logic [7:0]  m_asi [2];
  logic [26:0] m_ppn [2];
  logic        m_wr [2], m_se [2];

  logic [3:0] e_code;
  logic [39:0] e_pa;
  logic e_uc;
  logic [63:0] e_tag;
  string e_rq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dacl_unit u_dacl_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(va), .req_size(sz), .req_write(wr), .req_priv(pv), .req_hpriv(hp),
    .req_implicit(im), .req_amask(am), .req_nofault(nf), .req_real(rl),
    .req_asi(asi), .req_ctx(ctx), .req_state(st), .tlb_hit(th), .tlb_ppn(tppn),
    .tlb_priv(tpv), .tlb_wr(twr), .tlb_nfo(tnfo), .tlb_se(tse),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache), .tag_access(tag_access)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  // Expected verdict from the requirements; updates the model on acceptance.
  task automatic predict();
    logic [63:0] ev;
    logic veff [2];
    logic fill = 0, same, pres;
    int hs = -1;
    same = (st == m_st);
    for (int i = 0; i < 2; i++) veff[i] = m_v[i] && same;
    e_code = 0; e_pa = '0; e_uc = 0;
    ev = am ? (va & 64'hFFFF_FFFF) : va;
    if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin
      e_code = 1; e_rq = "R1";
    end else if (hp && im) begin
      e_pa = va[39:0]; e_rq = "R2";
    end else if (!am && va >= HLO && va <= HHI) begin
      e_code = 2; e_rq = "R3";
    end else begin
      for (int i = 1; i >= 0; i--)
        if (veff[i] && m_vpn[i] == ev[63:13] && m_asi[i] == asi && (!wr || m_wr[i])) hs = i;
      if (hs >= 0) begin
        e_pa = {m_ppn[hs], ev[12:0]}; e_uc = m_se[hs] | m_ppn[hs][26]; e_rq = "R8";
      end else if (!th) begin
        e_code = rl ? 4'd3 : 4'd4; e_rq = "R4";
      end else if (!pv && tpv) begin e_code = 5; e_rq = "R5";
      end else if (wr && !twr) begin e_code = 6; e_rq = "R5";
      end else if (tnfo && !nf) begin e_code = 7; e_rq = "R5";
      end else if (tse && nf) begin e_code = 8; e_rq = "R5";
      end else begin
        e_pa = {tppn, ev[12:0]}; e_uc = tse | tppn[26]; fill = 1; e_rq = "R6";
      end
    end
    if (e_code >= 3) m_tag = {ev[63:13], ctx};
    e_tag = m_tag;
    m_st = st;
    for (int i = 0; i < 2; i++) m_v[i] = veff[i];
    if (fill) begin
      pres = 0;
      for (int i = 0; i < 2; i++) if (veff[i] && m_vpn[i] == ev[63:13] && m_asi[i] == asi) pres = 1;
      if (!pres) begin
        m_v[1] = m_v[0]; m_vpn[1] = m_vpn[0]; m_asi[1] = m_asi[0];
        m_ppn[1] = m_ppn[0]; m_wr[1] = m_wr[0]; m_se[1] = m_se[0];
        m_v[0] = 1; m_vpn[0] = ev[63:13]; m_asi[0] = asi;
        m_ppn[0] = tppn; m_wr[0] = twr; m_se[0] = tse;
      end
    end
  endtask

  task automatic check_out(input string lbl);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_code !== e_code || rsp_pa !== e_pa ||
        rsp_uncache !== e_uc || tag_access !== e_tag) begin
      fails++;
      $display("FAIL %s %s: v=%0b code=%0d pa=%h uc=%0b tag=%h expected v=1 code=%0d pa=%h uc=%0b tag=%h",
               e_rq, lbl, rsp_valid, rsp_code, rsp_pa, rsp_uncache, tag_access,
               e_code, e_pa, e_uc, e_tag);
    end
  endtask

  task automatic xact(input string lbl);
    @(negedge clk);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    predict();
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check_out(lbl);
  endtask

  task automatic plain(input logic [63:0] a);
    va = a; sz = 3; wr = 0; pv = 1; hp = 0; im = 0; am = 0; nf = 0; rl = 0;
    th = 1; tpv = 0; twr = 1; tnfo = 0; tse = 0;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_asi[i] = '0; m_ppn[i] = '0; m_wr[i] = 0; m_se[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 / R7 reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1 || tag_access !== 64'd0) begin
      fails++;
      $display("FAIL R12 reset: v=%0b rdy=%0b tag=%h expected v=0 rdy=1 tag=0",
               rsp_valid, req_ready, tag_access);
    end

    st = 64'h11; asi = 8'h80; ctx = 13'h5;
    // R1 alignment sweep, with and without bypass
    for (int s = 0; s < 4; s++)
      for (int lo = 0; lo < 8; lo++)
        for (int b = 0; b < 2; b++) begin
          plain(64'h0000_0000_0004_A000 | 64'(lo)); sz = 2'(s);
          hp = b[0]; im = b[0]; tppn = 27'(s * 8 + lo);
          xact("R1 align");
        end

    // R2 bypass including an address in the hole
    plain(64'hFFFF_0000_1234_5678); hp = 1; im = 1; xact("R2 bypass");
    plain(64'h0000_00AB_CDEF_0000); hp = 1; im = 1; th = 0; xact("R2 bypass nohit");
    plain(64'h0000_0000_0007_0000); hp = 1; im = 0; tppn = 27'h4000123; xact("R2 hpriv explicit");

    // R3 hole bounds and masking
    plain(HLO - 64'd8); tppn = 27'h12; xact("R3 below");
    plain(HLO); xact("R3 lo");
    plain(HHI - 64'd7); xact("R3 hi");
    plain(HHI + 64'd1); tppn = 27'h13; xact("R3 above");
    plain(HLO | 64'h2000); am = 1; tppn = 27'h14; ctx = 13'h1ABC; xact("R3 masked");
    plain(64'hFFFF_FFFF_0000_4000); am = 1; th = 0; xact("R3 masked miss tag R7");

    // R4 R5 R6 R7: every mix of permission-related bits
    for (int k = 0; k < 512; k++) begin
      plain(64'(k + 256) << 13 | 64'h18);
      pv = k[0]; wr = k[1]; tpv = k[2]; twr = k[3]; tnfo = k[4]; tse = k[5];
      nf = k[6]; th = k[7]; rl = k[8]; ctx = 13'(k * 7);
      tppn = 27'(k * 12345) ^ {k[2], 26'd0};
      xact("R5 sweep");
    end

    // R8 R9: fill A, B, C, then revisit with the lookup missing
    st = 64'h22; asi = 8'h81;
    plain(64'h0000_0000_00A0_0000); tppn = 27'h0AAA; twr = 0; xact("R9 fill A");
    plain(64'h0000_0000_00B0_0000); tppn = 27'h0BBB; tse = 1; xact("R9 fill B");
    plain(64'h0000_0000_00C0_0000); tppn = 27'h4000CCC; xact("R9 fill C");
    plain(64'h0000_0000_00A0_0040); th = 0; xact("R9 A evicted");
    plain(64'h0000_0000_00B0_0100); th = 0; tppn = 27'h1; xact("R8 B hit");
    plain(64'h0000_0000_00C0_0008); th = 0; xact("R8 C hit");
    plain(64'h0000_0000_00C0_0008); th = 0; asi = 8'h82; xact("R8 asi differs");
    asi = 8'h81;
    plain(64'h0000_0000_00D0_0000); tppn = 27'h0DDD; twr = 0; xact("R9 fill D");
    plain(64'h0000_0000_00D0_0000); wr = 1; th = 0; xact("R8 write to read-only slot");
    plain(64'h0000_0000_00D0_0000); wr = 1; tppn = 27'h0EEE; xact("R9 present no shift");
    plain(64'h0000_0000_00C0_0000); th = 0; xact("R9 C kept");
    // R10 state change drops every slot
    st = 64'h23;
    plain(64'h0000_0000_00C0_0000); th = 0; xact("R10 after change");
    plain(64'h0000_0000_00D0_0000); th = 0; st = 64'h22; xact("R10 back to old state");

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    plain(64'h0000_0000_0123_4000); tppn = 27'h00F0; st = 64'h30;
    req_valid = 1;
    predict();
    @(posedge clk); @(negedge clk);
    plain(64'h0000_0000_0567_8000); tppn = 27'h00F1;
    for (int w = 0; w < 3; w++) begin
      check_out("R12 held");
      checks++;
      if (req_ready !== 1'b0) begin
        fails++;
        $display("FAIL R12 ready while held: actual=%0b expected=0", req_ready);
      end
      @(negedge clk);
    end
    rsp_ready = 1;
    predict();
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check_out("R12 next after drain");

    // mixed sweep over a small page pool so the slots see reuse
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, q;
      r = $urandom; q = $urandom;
      plain({48'd0, 3'(r[2:0]), 13'd0} | 64'(q[5:0]));
      if (r[31:29] == 3'd0) va = HLO | 64'(q[5:0]);
      sz = r[4:3]; wr = r[5]; pv = r[6] | r[7]; hp = r[8] & r[9]; im = r[10];
      am = r[11] & r[12]; nf = r[13] & r[14]; rl = r[15];
      asi = {7'h40, r[16]}; ctx = q[20:8];
      th = r[17] | r[18]; tpv = r[19] & r[20]; twr = r[21] | r[22];
      tnfo = r[23] & r[24]; tse = r[25] & r[26]; tppn = {q[31], q[21:0], 4'h3};
      if (r[28:27] == 2'd0 && q[7:6] == 2'd0) st = st + 1;
      xact("R6 mixed");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule